// File: doc/BRIEF.md
# Two-Phase Period Timer with Watchdog Reset

This peripheral holds two independent down-counting timers behind a small word-addressed register bus. A timer's period has two phases, each programmed by its own register: a high phase, during which the timer's output pin is driven high, then a low phase with the pin low. When the low phase runs out, the timer reloads the high-phase length and starts over, so it runs periodically until software turns it off.

Timer 1 drives the tick interrupt. It pulses for one cycle at the start of every new period, which makes it a periodic system tick. Timer 0 has no interrupt. It either runs as a plain periodic pin generator or, when its high-phase register carries a marker value, as a watchdog. In watchdog mode it counts once and then raises a sticky reset request. Software reprograms a timer by clearing its enable bit, rewriting its lengths and setting the bit again. Setting the bit always restarts the timer from the high phase.

Top module: `dual_phase_timer`

## Requirements
- R1: After reset every register reads 0, both timer outputs are low, and the tick interrupt and the reset request are low.
- R2: Register words are at byte address 0x00 (enables: bit 0 is timer 0 and bit 1 is timer 1, the other bits read 0), 0x04 (timer 0 high-phase length), 0x08 (timer 0 low-phase length), 0x0C (timer 1 high-phase length) and 0x10 (timer 1 low-phase length). A read strobe returns the addressed word on the read-data port in the next cycle. Read data is 0 in a cycle that follows no read strobe, and also for an unmapped or misaligned address. Writes to such addresses change nothing.
- R3: A timer advances only while its enable bit is 1. While the bit is 0 the timer holds its count and its output is low. A write that changes the bit from 0 to 1 restarts the timer in its high phase, using the current length registers, and the output is high from the next cycle.
- R4: In periodic mode the timer's output is high for max(H,1) cycles and then low for max(L,1) cycles, where H and L are the high- and low-phase lengths. The pattern repeats, so the shortest period is 2 cycles.
- R5: The tick interrupt is high for exactly one cycle, the first cycle of each new timer 1 period. That cycle comes max(H,1)+max(L,1) cycles after the enabling write and recurs once per period.
- R6: Timer 0 in periodic mode produces the same phase pattern on its own output and never raises the tick interrupt.
- R7: If bits [7:0] of timer 0's high-phase register are 0xFF when timer 0 is enabled, timer 0 is a watchdog with count N = bits [31:8]. Its output is high for max(N,1) cycles, after which the reset request goes high and the output goes low.
- R8: Clearing and then setting timer 0's enable bit before the watchdog expires restarts the full watchdog count.
- R9: Once high, the reset request stays high until the block is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| tmr_out | output | 2 | Phase output of each timer (bit i is timer i) |
| tick_irq | output | 1 | One-cycle tick pulse from timer 1 |
| reset_req | output | 1 | Sticky watchdog reset request |

## Verification
The assertions take for granted that the bus presents at most one access per cycle and that strobes are clean 0/1 levels. They also assume every phase lasts at least one cycle, so two ticks can never fall in back-to-back cycles. The bench drives each access for exactly one cycle, changes inputs only at the falling clock edge and uses lengths from 0 upwards. Zero and one therefore both exercise the one-cycle minimum without violating any of these assumptions.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned N_TMR   = 2;
  localparam int unsigned N_REG   = 1 + 2 * N_TMR;
  localparam int unsigned IDX_W   = ADDR_W - 2;
  localparam logic [7:0]  WD_MARK = 8'hFF;

  typedef enum logic [1:0] {
    PH_HIGH = 2'd0,
    PH_LOW  = 2'd1,
    PH_HALT = 2'd2
  } phase_e;
endpackage

// File: rtl/dpt_regfile.sv
module dpt_regfile
  import dpt_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         we,
  input  logic                         re,
  output logic [DATA_W-1:0]            rdata,
  output logic [N_TMR-1:0]             en_o,
  output logic [N_TMR-1:0]             start_o,
  output logic [N_TMR-1:0][DATA_W-1:0] len_hi_o,
  output logic [N_TMR-1:0][DATA_W-1:0] len_lo_o
);
  logic [DATA_W-1:0] cfg_q [N_REG];
  logic [IDX_W-1:0]  idx;
  logic              hit;

  assign idx = addr[ADDR_W-1:2];
  assign hit = (addr[1:0] == 2'b00) && (int'(idx) < N_REG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REG; i++) cfg_q[i] <= '0;
    end else if (we && hit) begin
      if (idx == '0) cfg_q[0] <= {{(DATA_W-N_TMR){1'b0}}, wdata[N_TMR-1:0]};
      else           cfg_q[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rdata <= '0;
    else if (re && hit) rdata <= cfg_q[idx];
    else                rdata <= '0;
  end

  assign en_o = cfg_q[0][N_TMR-1:0];

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr_regs
    assign len_hi_o[t] = cfg_q[1 + 2*t];
    assign len_lo_o[t] = cfg_q[2 + 2*t];
    assign start_o[t]  = we && hit && (idx == '0) && wdata[t] && !en_o[t];
  end
endmodule

// File: rtl/dpt_phase_counter.sv
module dpt_phase_counter
  import dpt_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter bit          HAS_WD  = 1'b0,
  parameter bit          HAS_IRQ = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             wd_i,
  input  logic [CNT_W-1:0] len_hi_i,
  input  logic [CNT_W-1:0] len_lo_i,
  output logic             out_o,
  output logic             wrap_o,
  output logic             fire_o
);
  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wd_q;
  logic             last;
  logic             step;

  assign last = (cnt_q <= CNT_W'(1));
  assign step = en_i && !start_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_HIGH;
      cnt_q <= '0;
      wd_q  <= 1'b0;
    end else if (start_i) begin
      ph_q  <= PH_HIGH;
      cnt_q <= len_hi_i;
      wd_q  <= HAS_WD && wd_i;
    end else if (en_i) begin
      unique case (ph_q)
        PH_HIGH: begin
          if (!last) cnt_q <= cnt_q - 1'b1;
          else if (wd_q) ph_q <= PH_HALT;
          else begin
            ph_q  <= PH_LOW;
            cnt_q <= len_lo_i;
          end
        end
        PH_LOW: begin
          if (!last) cnt_q <= cnt_q - 1'b1;
          else begin
            ph_q  <= PH_HIGH;
            cnt_q <= len_hi_i;
          end
        end
        default: ph_q <= PH_HALT;
      endcase
    end
  end

  assign out_o  = en_i && (ph_q == PH_HIGH);
  assign wrap_o = HAS_IRQ && step && (ph_q == PH_LOW) && last;
  assign fire_o = HAS_WD && step && (ph_q == PH_HIGH) && last && wd_q;
endmodule

// File: rtl/dual_phase_timer.sv
module dual_phase_timer
  import dpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_TMR-1:0]  tmr_out,
  output logic              tick_irq,
  output logic              reset_req
);
  localparam int unsigned WD_TMR  = 0;
  localparam int unsigned IRQ_TMR = 1;

  logic [N_TMR-1:0]             tmr_en;
  logic [N_TMR-1:0]             tmr_start;
  logic [N_TMR-1:0][DATA_W-1:0] len_hi;
  logic [N_TMR-1:0][DATA_W-1:0] len_lo;
  logic [N_TMR-1:0]             wrap;
  logic [N_TMR-1:0]             fire;

  dpt_regfile i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .we       (bus_we),
    .re       (bus_re),
    .rdata    (bus_rdata),
    .en_o     (tmr_en),
    .start_o  (tmr_start),
    .len_hi_o (len_hi),
    .len_lo_o (len_lo)
  );

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    localparam bit IS_WD = (t == WD_TMR);
    logic              wd_sel;
    logic [DATA_W-1:0] hi_len;

    if (IS_WD) begin : g_wd
      assign wd_sel = (len_hi[t][7:0] == WD_MARK);
      assign hi_len = wd_sel ? {8'h00, len_hi[t][DATA_W-1:8]} : len_hi[t];
    end else begin : g_plain
      assign wd_sel = 1'b0;
      assign hi_len = len_hi[t];
    end

    dpt_phase_counter #(
      .CNT_W   (DATA_W),
      .HAS_WD  (IS_WD),
      .HAS_IRQ (t == IRQ_TMR)
    ) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (tmr_en[t]),
      .start_i  (tmr_start[t]),
      .wd_i     (wd_sel),
      .len_hi_i (hi_len),
      .len_lo_i (len_lo[t]),
      .out_o    (tmr_out[t]),
      .wrap_o   (wrap[t]),
      .fire_o   (fire[t])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_irq  <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      tick_irq  <= |wrap;
      reset_req <= reset_req | (|fire);
    end
  end
endmodule

// File: rtl/dual_phase_timer_chk.sv
module dual_phase_timer_chk
  import dpt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_TMR-1:0]  tmr_out,
  input logic              tick_irq,
  input logic              reset_req,
  input logic [N_TMR-1:0]  tmr_en
);
  // R9: the request never drops without reset
  a_r9_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> reset_req);

  // R7: the request rises only after a cycle in which timer 0 was counting
  a_r7_req_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(tmr_out[0]));

  // R5: the tick lasts a single cycle
  a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |=> !tick_irq);

  // R5: a new period follows a low phase
  a_r5_tick_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_irq) |-> !$past(tmr_out[1]));

  // R2: read data is zero unless a read strobe came before
  a_r2_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == '0));

  // R3: the enabling write starts timer 1 in its high phase
  a_r3_enable_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0 && bus_wdata[1] && !tmr_en[1]) |=> tmr_out[1]);
endmodule

bind dual_phase_timer dual_phase_timer_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .tmr_out   (tmr_out),
  .tick_irq  (tick_irq),
  .reset_req (reset_req),
  .tmr_en    (tmr_en)
);

// File: tb/test_dual_phase_timer.sv
module test_dual_phase_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  tmr_out;
  logic        tick_irq;
  logic        reset_req;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  dual_phase_timer i_dual_phase_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .tmr_out(tmr_out), .tick_irq(tick_irq), .reset_req(reset_req)
  );

  // behavioural reference model
  logic [31:0] m_reg [5];
  int          m_ph  [2];
  longint      m_cnt [2];
  bit          m_wd  [2];
  bit          m_irq, m_rst;
  logic [31:0] m_rdata;
  int          mi;
  bit          m_hit, m_wdsel, m_start, m_fire, m_tick;
  longint      m_hi;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_reg[i] = 0;
      for (int t = 0; t < 2; t++) begin m_ph[t] = 0; m_cnt[t] = 0; m_wd[t] = 0; end
      m_irq = 0; m_rst = 0; m_rdata = 0;
    end else begin
      mi    = int'(bus_addr) / 4;
      m_hit = (bus_addr % 4 == 0) && (mi < 5);
      m_fire = 0; m_tick = 0;
      for (int t = 0; t < 2; t++) begin
        m_wdsel = (t == 0) && (m_reg[1][7:0] == 8'hFF);
        m_hi    = m_wdsel ? longint'(m_reg[1] >> 8) : longint'(m_reg[1 + 2*t]);
        m_start = bus_we && m_hit && (mi == 0) && bus_wdata[t] && !m_reg[0][t];
        if (m_start) begin
          m_ph[t] = 0; m_cnt[t] = m_hi; m_wd[t] = m_wdsel;
        end else if (m_reg[0][t]) begin
          if (m_ph[t] == 0) begin
            if (m_cnt[t] > 1) m_cnt[t]--;
            else if (m_wd[t]) begin m_ph[t] = 2; m_fire = 1; end
            else begin m_ph[t] = 1; m_cnt[t] = m_reg[2 + 2*t]; end
          end else if (m_ph[t] == 1) begin
            if (m_cnt[t] > 1) m_cnt[t]--;
            else begin m_ph[t] = 0; m_cnt[t] = m_hi; if (t == 1) m_tick = 1; end
          end
        end
      end
      m_irq = m_tick;
      m_rst = m_rst | m_fire;
      m_rdata = (bus_re && m_hit) ? m_reg[mi] : 32'd0;
      if (bus_we && m_hit) m_reg[mi] = (mi == 0) ? {30'd0, bus_wdata[1:0]} : bus_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int t = 0; t < 2; t++) begin
        chk(tmr_out[t] == (m_reg[0][t] && m_ph[t] == 0), "R4 phase output",
            tmr_out[t], (m_reg[0][t] && m_ph[t] == 0));
      end
      chk(tick_irq == m_irq, "R5 tick", tick_irq, m_irq);
      chk(reset_req == m_rst, "R7 reset request", reset_req, m_rst);
      chk(bus_rdata == m_rdata, "R2 read data", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    chk(bus_rdata == exp, req, bus_rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cycles_until_tick(output int k);
    k = 0;
    while (!tick_irq && k < 200) begin @(negedge clk); k++; end
  endtask

  initial begin
    int k;
    int hi_n, lo_n;
    @(negedge clk);
    do_reset();
    cmp_on = 1'b1;
    // R1 reset state
    chk(tmr_out == 2'b00 && !tick_irq && !reset_req, "R1 outputs after reset",
        {tmr_out, tick_irq, reset_req}, 0);
    for (int a = 0; a < 5; a++) rd(5'(a*4), 32'd0, "R1 register after reset");

    // R2 readback, masking, unmapped
    wr(5'h04, 32'h1234_5678); wr(5'h08, 32'hDEAD_BEEF);
    wr(5'h0C, 32'h0000_00A5); wr(5'h10, 32'h5A5A_0001);
    wr(5'h14, 32'hFFFF_FFFF); wr(5'h06, 32'h0000_0077);
    rd(5'h04, 32'h1234_5678, "R2 timer0 high length");
    rd(5'h08, 32'hDEAD_BEEF, "R2 timer0 low length");
    rd(5'h0C, 32'h0000_00A5, "R2 timer1 high length");
    rd(5'h10, 32'h5A5A_0001, "R2 timer1 low length");
    rd(5'h14, 32'd0, "R2 unmapped read");
    rd(5'h05, 32'd0, "R2 misaligned read");
    wr(5'h00, 32'hFFFF_FFFC);
    rd(5'h00, 32'd0, "R2 control upper bits");
    chk(tmr_out == 2'b00, "R3 no enable no output", tmr_out, 0);

    // R5 tick spacing with H=3, L=2
    wr(5'h0C, 32'd3); wr(5'h10, 32'd2);
    wr(5'h00, 32'd2);
    chk(tmr_out[1] == 1'b1, "R3 high right after enable", tmr_out[1], 1);
    cycles_until_tick(k);
    chk(k == 5, "R5 first tick", k, 5);
    @(negedge clk);
    cycles_until_tick(k);
    chk(k == 4, "R5 tick period", k + 1, 5);

    // R3 disable holds, re-enable restarts
    wr(5'h00, 32'd0);
    repeat (6) @(negedge clk);
    chk(tmr_out[1] == 1'b0 && !tick_irq, "R3 disabled output low", tmr_out[1], 0);
    wr(5'h0C, 32'd0); wr(5'h10, 32'd0);
    wr(5'h00, 32'd2);
    cycles_until_tick(k);
    chk(k == 2, "R4 minimum period", k, 2);

    // R6 timer0 periodic, H=2 L=4, run next to timer1
    wr(5'h04, 32'd2); wr(5'h08, 32'd4);
    wr(5'h00, 32'd3);
    hi_n = 0; lo_n = 0;
    while (tmr_out[0] && hi_n < 50) begin @(negedge clk); hi_n++; end
    while (!tmr_out[0] && lo_n < 50) begin @(negedge clk); lo_n++; end
    chk(hi_n == 2, "R6 timer0 high phase", hi_n, 2);
    chk(lo_n == 4, "R6 timer0 low phase", lo_n, 4);
    repeat (30) @(negedge clk);
    chk(!reset_req, "R6 periodic timer0 no reset request", reset_req, 0);

    // R7/R8 watchdog with count 5 and one kick
    do_reset();
    wr(5'h04, (32'd5 << 8) | 32'hFF);
    wr(5'h00, 32'd1);
    repeat (3) @(negedge clk);
    wr(5'h00, 32'd0);
    wr(5'h00, 32'd1);
    k = 0;
    while (!reset_req && k < 100) begin @(negedge clk); k++; end
    chk(k == 5, "R8 kick restarts count", k, 5);
    chk(tmr_out[0] == 1'b0, "R7 output low after expiry", tmr_out[0], 0);
    wr(5'h00, 32'd0);
    repeat (10) @(negedge clk);
    chk(reset_req == 1'b1, "R9 request sticky", reset_req, 1);
    do_reset();
    chk(reset_req == 1'b0, "R9 cleared by reset", reset_req, 0);
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule